// File: doc/BRIEF.md
# Hashed Page Table Walker

This block translates one effective address at a time by searching a hashed page table held in memory. The caller supplies a 32-bit effective address, the segment register value already selected by that address's top four bits, an access-type flag (write or not), and the table base and mask. The walker hashes the segment ID with the page index and scans a 64-byte group of eight 8-byte entries. If no entry in that group matches, it scans a second group found with the complemented hash.

On a hit the walker reads the entry's second word. It sets the referenced bit, and also the changed bit on a write. It writes the word back only when the value has changed. It then reports the updated word, the entry address, the real address and a write-allow flag. A non-write hit never grants write permission, so a later store walks the table again and marks the page changed. Memory is reached through a single 32-bit request/ready port whose latency may vary.

Top module: `hpt_walker`

## Requirements
- R1: With vsid = seg_i[23:0] and pgidx = ea_i[27:12], the hash is vsid XOR pgidx, zero-extended to 32 bits. The first-pass group address is tbl_base_i OR ((hash << 6) AND tbl_mask_i). The second pass uses the 32-bit complement of the hash in place of the hash.
- R2: An entry's first word hits only when three conditions hold. Bit 31 (valid) must be 1. Bit 6 (secondary flag) must equal the pass (0 first, 1 second). Bits 30:7 must equal vsid and bits 5:0 must equal pgidx[15:10].
- R3: The first word of each entry is read at group address + 8*i for i = 0..7 in ascending order, and the scan stops at the first hit. The second group is read only after all eight first-pass entries miss. The second word is read at entry address + 4, and only after a hit.
- R4: When both groups miss, the walk ends after exactly 16 reads with hit_o = 0 and pte_lo_o, pte_addr_o, real_addr_o and wr_allow_o all zero.
- R5: On a hit the new second word is the old word OR bit 8 (referenced), and also OR bit 7 (changed) when wr_i was 1. It is written to entry address + 4 only if it differs from the old word.
- R6: On a hit, pte_lo_o is the updated second word and pte_addr_o is the address of the entry's first word. real_addr_o is {pte_lo_o[31:12], ea_i[11:0]}.
- R7: wr_allow_o is 1 only for a hit on a write access, and 0 for a hit on a non-write access.
- R8: Once mem_req_o is raised, it stays high with mem_addr_o, mem_we_o and mem_wdata_o unchanged until mem_rdy_i is sampled high. A transfer completes on each clock edge where both are high.
- R9: busy_o rises the cycle after an accepted start_i and stays high until the cycle in which done_o pulses for exactly one cycle. A start_i while busy_o is high is ignored. Results hold until the next accepted start.
- R10: After reset, busy_o, done_o and mem_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a walk (accepted when idle) |
| ea_i | input | 32 | Effective address |
| seg_i | input | 32 | Selected segment register value |
| wr_i | input | 1 | Access is a write |
| tbl_base_i | input | 32 | Page table base address |
| tbl_mask_i | input | 32 | Group offset mask |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | Transfer is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdy_i | input | 1 | Memory completes the transfer |
| mem_rdata_i | input | 32 | Read data, valid with mem_rdy_i |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| hit_o | output | 1 | Matching entry found |
| pte_lo_o | output | 32 | Updated second word of the entry |
| pte_addr_o | output | 32 | Address of the entry's first word |
| real_addr_o | output | 32 | Translated real address |
| wr_allow_o | output | 1 | Write permission may be granted |

## Verification
The assertions rely on two properties of the memory. Read data must be valid in every cycle that mem_rdy_i is high. Ready must never be returned unless a request is pending. The bench memory model gives both: it raises ready only while mem_req_o is high, for one cycle, with data from its array, after a latency that cycles through 0 to 3 wait states. The checks also assume start_i is acted on only from idle and that the table mask keeps group addresses inside the modelled 16 KB memory. The stimulus uses base 0 and mask 0x3FC0 so every walk stays inside the array.

// File: rtl/hpt_pkg.sv
// hpt_pkg: shared state encoding and entry bit positions for the page
// table walker. Assumes 32-bit words and the entry layout in the brief.
package hpt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_TAG,
        ST_RD_LO,
        ST_WRBACK,
        ST_FIN
    } walk_state_t;

    localparam int VALID_BIT = 31;
    localparam int SEC_BIT   = 6;
    localparam int REF_BIT   = 8;
    localparam int CHG_BIT   = 7;
endpackage

// File: rtl/hpt_hash.sv
// hpt_hash: forms the compare tag and the group byte address for the
// current pass. Pure combinational; assumes the group size is a power of 2.
module hpt_hash #(
    parameter int GROUP_LOG2 = 6
) (
    input  logic [31:0] ea_i,
    input  logic [31:0] seg_i,
    input  logic [31:0] base_i,
    input  logic [31:0] mask_i,
    input  logic        pass_i,
    output logic [30:0] tag_o,
    output logic [31:0] grp_addr_o
);
    logic [23:0] vsid;
    logic [15:0] pgidx;
    logic [31:0] hash;
    logic [31:0] hsel;

    // Hash, pass-dependent complement and masked group offset.
    always_comb begin
        vsid       = seg_i[23:0];
        pgidx      = ea_i[27:12];
        hash       = {8'h00, vsid ^ {8'h00, pgidx}};
        hsel       = pass_i ? ~hash : hash;
        tag_o      = {vsid, 1'b0, pgidx[15:10]};
        grp_addr_o = base_i | ((hsel << GROUP_LOG2) & mask_i);
    end
endmodule

// File: rtl/hpt_match.sv
// hpt_match: decides whether a fetched first word hits the compare tag
// in the current pass. Assumes the tag carries zero in the flag position.
module hpt_match (
    input  logic [31:0] word_i,
    input  logic [30:0] tag_i,
    input  logic        pass_i,
    output logic        hit_o
);
    import hpt_pkg::*;

    // Valid bit, pass flag and tag bits must all agree.
    always_comb begin
        hit_o = word_i[VALID_BIT]
              && (word_i[SEC_BIT] == pass_i)
              && (word_i[30:SEC_BIT+1] == tag_i[30:SEC_BIT+1])
              && (word_i[SEC_BIT-1:0] == tag_i[SEC_BIT-1:0]);
    end
endmodule

// File: rtl/hpt_seq.sv
// hpt_seq: walk controller. Latches the request, steps through the entries
// of each group, fetches and updates the second word on a hit, and drives
// the memory port. Assumes memory holds its response until ready is seen.
module hpt_seq #(
    parameter int GROUP_ENTRIES = 8,
    parameter int ENTRY_BYTES   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [31:0] ea_i,
    input  logic [31:0] seg_i,
    input  logic        wr_i,
    input  logic [31:0] base_i,
    input  logic [31:0] mask_i,
    output logic [31:0] ea_q_o,
    output logic [31:0] seg_q_o,
    output logic [31:0] base_q_o,
    output logic [31:0] mask_q_o,
    output logic        pass_o,
    input  logic [31:0] grp_addr_i,
    input  logic        match_i,
    output logic        mem_req_o,
    output logic        mem_we_o,
    output logic [31:0] mem_addr_o,
    output logic [31:0] mem_wdata_o,
    input  logic        mem_rdy_i,
    input  logic [31:0] mem_rdata_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        hit_o,
    output logic [31:0] pte_lo_o,
    output logic [31:0] pte_addr_o,
    output logic [31:0] real_addr_o,
    output logic        wr_allow_o
);
    import hpt_pkg::*;

    localparam int IDX_W   = (GROUP_ENTRIES > 1) ? $clog2(GROUP_ENTRIES) : 1;
    localparam int ESH     = $clog2(ENTRY_BYTES);
    localparam int LO_OFF  = ENTRY_BYTES / 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

    walk_state_t      st;
    logic [IDX_W-1:0] idx;
    logic             pass_q;
    logic             wr_q;
    logic [31:0]      ea_q, seg_q, base_q, mask_q;
    logic             hit_q, wal_q;
    logic [31:0]      lo_q, paddr_q;
    logic [31:0]      ent_addr;
    logic [31:0]      upd_word;

    // Address of the current entry's first word.
    always_comb begin
        ent_addr = grp_addr_i + (32'(idx) << ESH);
    end

    // Second word with the referenced bit and, for writes, the changed bit set.
    always_comb begin
        upd_word = mem_rdata_i;
        upd_word[REF_BIT] = 1'b1;
        if (wr_q) begin
            upd_word[CHG_BIT] = 1'b1;
        end
    end

    // Walk state machine and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            idx     <= '0;
            pass_q  <= 1'b0;
            wr_q    <= 1'b0;
            ea_q    <= '0;
            seg_q   <= '0;
            base_q  <= '0;
            mask_q  <= '0;
            hit_q   <= 1'b0;
            wal_q   <= 1'b0;
            lo_q    <= '0;
            paddr_q <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        ea_q    <= ea_i;
                        seg_q   <= seg_i;
                        wr_q    <= wr_i;
                        base_q  <= base_i;
                        mask_q  <= mask_i;
                        pass_q  <= 1'b0;
                        idx     <= '0;
                        hit_q   <= 1'b0;
                        wal_q   <= 1'b0;
                        lo_q    <= '0;
                        paddr_q <= '0;
                        st      <= ST_RD_TAG;
                    end
                end
                ST_RD_TAG: begin
                    if (mem_rdy_i) begin
                        if (match_i) begin
                            st <= ST_RD_LO;
                        end else if (idx == LAST_IDX) begin
                            if (!pass_q) begin
                                pass_q <= 1'b1;
                                idx    <= '0;
                            end else begin
                                st <= ST_FIN;
                            end
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_RD_LO: begin
                    if (mem_rdy_i) begin
                        hit_q   <= 1'b1;
                        wal_q   <= wr_q;
                        lo_q    <= upd_word;
                        paddr_q <= ent_addr;
                        st      <= (upd_word != mem_rdata_i) ? ST_WRBACK : ST_FIN;
                    end
                end
                ST_WRBACK: begin
                    if (mem_rdy_i) begin
                        st <= ST_FIN;
                    end
                end
                default: begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end

    // Memory port and status outputs decoded from the state.
    always_comb begin
        mem_req_o   = (st == ST_RD_TAG) || (st == ST_RD_LO) || (st == ST_WRBACK);
        mem_we_o    = (st == ST_WRBACK);
        mem_addr_o  = (st == ST_RD_TAG) ? ent_addr : ent_addr + 32'(LO_OFF);
        mem_wdata_o = lo_q;
        busy_o      = (st != ST_IDLE) && (st != ST_FIN);
        done_o      = (st == ST_FIN);
    end

    // Result outputs.
    always_comb begin
        hit_o       = hit_q;
        wr_allow_o  = wal_q;
        pte_lo_o    = lo_q;
        pte_addr_o  = paddr_q;
        real_addr_o = hit_q ? {lo_q[31:12], ea_q[11:0]} : 32'h0;
        ea_q_o      = ea_q;
        seg_q_o     = seg_q;
        base_q_o    = base_q;
        mask_q_o    = mask_q;
        pass_o      = pass_q;
    end
endmodule

// File: rtl/hpt_walker.sv
// hpt_walker: top of the hashed page table walker. Connects the hash unit,
// the entry matcher and the walk controller. Assumes a memory that answers
// one word per ready handshake.
module hpt_walker #(
    parameter int GROUP_ENTRIES = 8,
    parameter int ENTRY_BYTES   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [31:0] ea_i,
    input  logic [31:0] seg_i,
    input  logic        wr_i,
    input  logic [31:0] tbl_base_i,
    input  logic [31:0] tbl_mask_i,
    output logic        mem_req_o,
    output logic        mem_we_o,
    output logic [31:0] mem_addr_o,
    output logic [31:0] mem_wdata_o,
    input  logic        mem_rdy_i,
    input  logic [31:0] mem_rdata_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        hit_o,
    output logic [31:0] pte_lo_o,
    output logic [31:0] pte_addr_o,
    output logic [31:0] real_addr_o,
    output logic        wr_allow_o
);
    localparam int GROUP_LOG2 = $clog2(GROUP_ENTRIES * ENTRY_BYTES);

    logic [31:0] ea_q, seg_q, base_q, mask_q;
    logic        pass;
    logic [30:0] tag;
    logic [31:0] grp_addr;
    logic        match;

    hpt_hash #(.GROUP_LOG2(GROUP_LOG2)) u_hash (
        .ea_i      (ea_q),
        .seg_i     (seg_q),
        .base_i    (base_q),
        .mask_i    (mask_q),
        .pass_i    (pass),
        .tag_o     (tag),
        .grp_addr_o(grp_addr)
    );

    hpt_match u_match (
        .word_i(mem_rdata_i),
        .tag_i (tag),
        .pass_i(pass),
        .hit_o (match)
    );

    hpt_seq #(
        .GROUP_ENTRIES(GROUP_ENTRIES),
        .ENTRY_BYTES  (ENTRY_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ea_i       (ea_i),
        .seg_i      (seg_i),
        .wr_i       (wr_i),
        .base_i     (tbl_base_i),
        .mask_i     (tbl_mask_i),
        .ea_q_o     (ea_q),
        .seg_q_o    (seg_q),
        .base_q_o   (base_q),
        .mask_q_o   (mask_q),
        .pass_o     (pass),
        .grp_addr_i (grp_addr),
        .match_i    (match),
        .mem_req_o  (mem_req_o),
        .mem_we_o   (mem_we_o),
        .mem_addr_o (mem_addr_o),
        .mem_wdata_o(mem_wdata_o),
        .mem_rdy_i  (mem_rdy_i),
        .mem_rdata_i(mem_rdata_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .hit_o      (hit_o),
        .pte_lo_o   (pte_lo_o),
        .pte_addr_o (pte_addr_o),
        .real_addr_o(real_addr_o),
        .wr_allow_o (wr_allow_o)
    );
endmodule

// File: rtl/hpt_walker_chk.sv
// hpt_walker_chk: port-level properties of the walker, bound to every
// instance. Assumes memory raises ready only while a request is pending.
module hpt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req_o,
    input logic        mem_we_o,
    input logic [31:0] mem_addr_o,
    input logic [31:0] mem_wdata_o,
    input logic        mem_rdy_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        hit_o,
    input logic [31:0] pte_lo_o,
    input logic [31:0] real_addr_o,
    input logic        wr_allow_o
);
    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o)
                                    && $stable(mem_we_o) && $stable(mem_wdata_o));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    // R5
    wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o |-> mem_wdata_o[8]);
    // R7
    wallow_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_allow_o |-> hit_o);
    // R6
    raddr_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && hit_o |-> real_addr_o[31:12] == pte_lo_o[31:12] && pte_lo_o[8]);
    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !hit_o |-> pte_lo_o == 32'h0 && real_addr_o == 32'h0 && !wr_allow_o);
endmodule

bind hpt_walker hpt_walker_chk u_chk (.*);

// File: tb/hpt_walker_tb.sv
module hpt_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] ea_i = '0, seg_i = '0;
    logic        wr_i = 1'b0;
    logic [31:0] tbl_base_i = 32'h0, tbl_mask_i = 32'h0000_3FC0;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic        mem_rdy_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        busy_o, done_o, hit_o, wr_allow_o;
    logic [31:0] pte_lo_o, pte_addr_o, real_addr_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    hpt_walker u_dut (.*);

    typedef struct {
        logic        hit;
        logic [31:0] lo;
        logic [31:0] addr;
        logic [31:0] raddr;
        logic        wal;
        int          reads;
        int          writes;
    } exp_t;

    exp_t  q[$];
    logic [31:0] mem [0:4095];
    int    n_reads = 0, n_writes = 0;
    int    lat = 0, lat_seq = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] grp(input logic [31:0] ea, input logic [31:0] seg, input bit pass);
        logic [31:0] h;
        h = {8'h0, seg[23:0] ^ {8'h0, ea[27:12]}};
        if (pass) h = ~h;
        return tbl_base_i | ((h << 6) & tbl_mask_i);
    endfunction

    function automatic logic [31:0] mk_w0(input logic [31:0] ea, input logic [31:0] seg,
                                          input bit pass, input bit valid);
        return {valid, seg[23:0], pass, ea[27:22]};
    endfunction

    // Reference model from R1-style rules (scan, match, update).
    function automatic exp_t model(input logic [31:0] ea, input logic [31:0] seg, input bit wr);
        exp_t e;
        e = '{hit:1'b0, lo:32'h0, addr:32'h0, raddr:32'h0, wal:1'b0, reads:0, writes:0};
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 8; i++) begin
                logic [31:0] a, w0, w1, nw;
                a  = grp(ea, seg, p[0]) + 32'(i * 8);
                w0 = mem[a[13:2]];
                e.reads++;
                if (w0[31] && w0[6] == p[0] && w0[30:7] == seg[23:0] && w0[5:0] == ea[27:22]) begin
                    w1 = mem[(a + 4) >> 2];
                    e.reads++;
                    nw = w1 | 32'h100 | (wr ? 32'h80 : 32'h0);
                    e.hit = 1'b1; e.lo = nw; e.addr = a;
                    e.raddr = {nw[31:12], ea[11:0]};
                    e.wal = wr;
                    e.writes = (nw != w1) ? 1 : 0;
                    return e;
                end
            end
        end
        return e;
    endfunction

    // Driver: compute expectation, queue it, pulse start.
    task automatic lookup(input logic [31:0] ea, input logic [31:0] seg, input bit wr);
        exp_t e;
        e = model(ea, seg, wr);
        q.push_back(e);
        @(negedge clk);
        n_reads = 0; n_writes = 0;
        ea_i = ea; seg_i = seg; wr_i = wr; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R9", "busy after start", {31'h0, busy_o}, 32'h1);
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Memory: ready with rotating latency, only while a request is pending.
    always @(negedge clk) begin
        if (mem_rdy_i) begin
            mem_rdy_i = 1'b0;
        end else if (mem_req_o) begin
            if (lat == 0) begin
                mem_rdy_i   = 1'b1;
                mem_rdata_i = mem[mem_addr_o[13:2]];
                lat_seq++;
                lat = lat_seq % 4;
            end else begin
                lat--;
            end
        end
    end

    // Memory handshakes: count transfers and apply writes.
    always @(posedge clk) begin
        if (mem_req_o && mem_rdy_i) begin
            if (mem_we_o) begin
                mem[mem_addr_o[13:2]] = mem_wdata_o;
                n_writes++;
            end else begin
                n_reads++;
            end
        end
    end

    // Monitor: pop and compare on each done pulse.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (q.size() == 0) begin
                check(1'b0, "R9", "unexpected done", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(hit_o === e.hit, e.hit ? "R2" : "R4", "hit", {31'h0, hit_o}, {31'h0, e.hit});
                check(pte_lo_o === e.lo, "R5", "pte_lo", pte_lo_o, e.lo);
                check(pte_addr_o === e.addr, "R6", "pte_addr", pte_addr_o, e.addr);
                check(real_addr_o === e.raddr, "R6", "real_addr", real_addr_o, e.raddr);
                check(wr_allow_o === e.wal, "R7", "wr_allow", {31'h0, wr_allow_o}, {31'h0, e.wal});
                check(n_reads == e.reads, "R3", "read count", 32'(n_reads), 32'(e.reads));
                check(n_writes == e.writes, "R5", "write count", 32'(n_writes), 32'(e.writes));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] ea, seg, g, ea2, seg2, ea3, seg3, g1, g2, ea4, seg4;
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        ea  = 32'h3456_7ABC; seg = 32'h0000_0123;
        g   = grp(ea, seg, 1'b0);
        // R2: entry 1 valid but other segment, entry 2 right tag but invalid
        mem[(g + 8) >> 2]  = mk_w0(ea, 32'h0000_0999, 1'b0, 1'b1);
        mem[(g + 16) >> 2] = mk_w0(ea, seg, 1'b0, 1'b0);
        mem[(g + 24) >> 2] = mk_w0(ea, seg, 1'b0, 1'b1);
        mem[(g + 28) >> 2] = 32'h0ABC_D002;
        // R3: secondary hit; primary holds same tag with flag 1 (must not hit)
        ea2 = 32'h1000_5444; seg2 = 32'h0000_00AB;
        g1 = grp(ea2, seg2, 1'b0); g2 = grp(ea2, seg2, 1'b1);
        mem[g1 >> 2]        = mk_w0(ea2, seg2, 1'b1, 1'b1);
        mem[(g2 + 40) >> 2] = mk_w0(ea2, seg2, 1'b1, 1'b1);
        mem[(g2 + 44) >> 2] = 32'h7777_7001;
        // R5: entry already referenced and changed
        ea4 = 32'h5012_3008; seg4 = 32'h0000_3210;
        g   = grp(ea4, seg4, 1'b0);
        mem[g >> 2]       = mk_w0(ea4, seg4, 1'b0, 1'b1);
        mem[(g + 4) >> 2] = 32'h0001_2183;
        ea3 = 32'h2ABC_D123; seg3 = 32'h0000_0F0F;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        check(busy_o === 1'b0, "R10", "busy after reset", {31'h0, busy_o}, 32'h0);
        check(done_o === 1'b0, "R10", "done after reset", {31'h0, done_o}, 32'h0);
        check(mem_req_o === 1'b0, "R10", "req after reset", {31'h0, mem_req_o}, 32'h0);

        lookup(ea, seg, 1'b0);  wait_idle();   // R5 ref set, R7 no write allow
        check(mem[(grp(ea, seg, 1'b0) + 28) >> 2] === 32'h0ABC_D102, "R5", "stored word",
              mem[(grp(ea, seg, 1'b0) + 28) >> 2], 32'h0ABC_D102);
        lookup(ea, seg, 1'b0);  wait_idle();   // R5 no write when unchanged
        lookup(ea, seg, 1'b1);  wait_idle();   // R5 changed bit, R7 allow
        lookup(ea, seg, 1'b1);  wait_idle();
        lookup(ea2, seg2, 1'b0); wait_idle();  // R3 secondary pass
        lookup(ea3, seg3, 1'b1); wait_idle();  // R4 miss
        lookup(ea4, seg4, 1'b1); wait_idle();  // R5 already set, no write

        // R9: start while busy is ignored; result matches first request only
        lookup(ea2, seg2, 1'b1);
        @(negedge clk);
        ea_i = ea3; seg_i = seg3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        check(busy_o === 1'b0, "R9", "idle after ignored start", {31'h0, busy_o}, 32'h0);
        check(pte_addr_o === grp(ea2, seg2, 1'b1) + 40, "R9", "result held",
              pte_addr_o, grp(ea2, seg2, 1'b1) + 40);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule